// File: doc/BRIEF.md
# Static branch and return predictor

This block sits beside a simple in-order fetch unit and guesses, in the same cycle, where fetch goes next. For each incoming instruction it receives a pre-decoded class, the instruction's address and its signed word displacement. It returns a taken flag and a next-fetch address. Jumps and calls are always taken. A conditional branch is taken only when it points backwards, that is, when its displacement is negative. Returns take their target from a shallow return-address stack that calls fill.

Instructions arrive on a valid/ready stream, and predictions leave on a valid/ready stream in the same cycle. The block holds no data of its own on the path, so `in_ready` simply follows `out_ready`. An instruction is consumed only in a cycle where `in_valid` and `out_ready` are both high. Only a consumed instruction may change the stack. While the consumer stalls, the prediction stays a pure function of the held input and of the current stack. The `redirect` pin is a plain control input from execute: it empties the stack, and a call presented in the same cycle does not push.

Top module: `static_fetch_predictor`

## Requirements
- R1: A conditional branch (class 1) with a negative displacement is predicted taken, with target PC + 4 + 4·sext(displacement).
- R2: A conditional branch with a zero or positive displacement is predicted not taken, with target PC + 4.
- R3: A jump (class 2) is predicted taken, with target PC + 4 + 4·sext(displacement).
- R4: A call (class 3) is predicted taken to the same computed target. When consumed, it pushes PC + 4 onto the return stack.
- R5: A return (class 4) on a non-empty stack is predicted taken to the most recently pushed address. When consumed, it pops that address, so returns are served in last-in, first-out order.
- R6: The stack holds DEPTH entries, where DEPTH is a parameter from 2 to 4. A push onto a full stack drops the oldest entry and keeps the newest DEPTH entries.
- R7: A return on an empty stack, including the first return after reset, is predicted not taken with target PC + 4 and `pred_valid` low.
- R8: When `redirect` is high at a clock edge, the stack is empty in the next cycle, and a call in that same cycle does not push.
- R9: Any other class (class 0, or any unused code) is predicted not taken, with target PC + 4.
- R10: `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`. Without a transfer the stack does not change. `pred_valid` and `pred_taken` are low whenever `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the stack starts empty |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can accept the instruction |
| in_class | input | 3 | 0 other, 1 conditional, 2 jump, 3 call, 4 return |
| in_pc | input | 32 | Instruction address |
| in_disp | input | DISP_W | Signed word displacement |
| redirect | input | 1 | Flush from execute; empties the stack |
| out_valid | output | 1 | Prediction present |
| out_ready | input | 1 | Consumer accepts the prediction |
| pred_taken | output | 1 | Predicted taken |
| pred_valid | output | 1 | Low for a return on an empty stack or when idle |
| pred_target | output | 32 | Predicted next-fetch address |

## Verification
A wrong stack pointer or a wrong occupancy count stays hidden until the next return. At that point it shows up as a wrong target, as a taken flag where none is expected, or as `pred_valid` dropping too early or too late. The bench therefore mixes deep call chains, overflow, stalled transfers and redirects with later returns. It compares every output on every cycle against a queue model, so the first bad return is flagged in the cycle it is presented.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int CLS_W = 3;
  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER = 3'd0,
    CLS_COND  = 3'd1,
    CLS_JUMP  = 3'd2,
    CLS_CALL  = 3'd3,
    CLS_RET   = 3'd4
  } instr_class_e;
  localparam int ADDR_W = 32;
endpackage

// File: rtl/sfp_target.sv
module sfp_target #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 21
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] br_addr
);
  logic [ADDR_W-1:0] off;
  always_comb begin
    off      = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp} << 2;
    seq_addr = pc + ADDR_W'(4);
    br_addr  = seq_addr + off;
  end
endmodule

// File: rtl/sfp_ras.sv
module sfp_ras #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] top_addr,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction
  function automatic logic [PTR_W-1:0] prv(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH-1) : p - PTR_W'(1);
  endfunction

  assign empty    = (count == '0);
  assign top_addr = mem[prv(ptr)];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ptr   <= '0;
      count <= '0;
    end else if (push) begin
      mem[ptr] <= push_addr;
      ptr      <= nxt(ptr);
      if (count != CNT_W'(DEPTH)) count <= count + CNT_W'(1);
    end else if (pop && !empty) begin
      ptr   <= prv(ptr);
      count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/static_fetch_predictor.sv
module static_fetch_predictor
  import sfp_pkg::*;
#(
  parameter int DISP_W = 21,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CLS_W-1:0]  in_class,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [DISP_W-1:0] in_disp,
  input  logic              redirect,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              pred_taken,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_target
);
  logic [ADDR_W-1:0] seq_addr, br_addr, top_addr;
  logic              ras_empty, fire, push, pop;
  logic [CNT_W-1:0]  ras_count;

  sfp_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc(in_pc), .disp(in_disp), .seq_addr(seq_addr), .br_addr(br_addr)
  );

  sfp_ras #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ras (
    .clk(clk), .rst_n(rst_n), .flush(redirect), .push(push), .pop(pop),
    .push_addr(seq_addr), .top_addr(top_addr), .empty(ras_empty),
    .count(ras_count)
  );

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign fire      = in_valid && out_ready;
  assign push      = fire && !redirect && (in_class == CLS_CALL);
  assign pop       = fire && !redirect && (in_class == CLS_RET) && !ras_empty;

  // Priority: unconditional and call, then conditional, then return stack.
  always_comb begin
    pred_taken  = 1'b0;
    pred_valid  = in_valid;
    pred_target = seq_addr;
    if (in_class == CLS_JUMP || in_class == CLS_CALL) begin
      pred_taken  = in_valid;
      pred_target = br_addr;
    end else if (in_class == CLS_COND) begin
      if (in_disp[DISP_W-1]) begin
        pred_taken  = in_valid;
        pred_target = br_addr;
      end
    end else if (in_class == CLS_RET) begin
      if (ras_empty) begin
        pred_valid = 1'b0;
      end else begin
        pred_taken  = in_valid;
        pred_target = top_addr;
      end
    end
  end
endmodule

// File: rtl/static_fetch_predictor_chk.sv
module static_fetch_predictor_chk
  import sfp_pkg::*;
#(
  parameter int DISP_W = 21,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CLS_W-1:0]  in_class,
  input logic [ADDR_W-1:0] in_pc,
  input logic [DISP_W-1:0] in_disp,
  input logic              redirect,
  input logic              out_ready,
  input logic              pred_taken,
  input logic              pred_valid,
  input logic [ADDR_W-1:0] pred_target,
  input logic [CNT_W-1:0]  ras_count
);
  initial begin
    a_depth_range_r6: assert (DEPTH >= 2 && DEPTH <= 4);
  end

  p_cond_back_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == CLS_COND && in_disp[DISP_W-1]) |-> pred_taken);

  p_cond_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_class == CLS_COND && !in_disp[DISP_W-1]) |->
      (!pred_taken && pred_target == in_pc + 32'd4));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ras_count <= CNT_W'(DEPTH));

  p_empty_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_class == CLS_RET && ras_count == '0) |-> (!pred_valid && !pred_taken));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (ras_count == '0));

  p_hold_stack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && out_ready) && !redirect) |=> $stable(ras_count));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!pred_valid && !pred_taken));
endmodule

bind static_fetch_predictor static_fetch_predictor_chk #(
  .DISP_W(DISP_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
  .in_pc(in_pc), .in_disp(in_disp), .redirect(redirect),
  .out_ready(out_ready), .pred_taken(pred_taken), .pred_valid(pred_valid),
  .pred_target(pred_target), .ras_count(ras_count)
);

// File: tb/tb_static_fetch_predictor.sv
`timescale 1ns/1ps
module tb_static_fetch_predictor;
  localparam int DISP_W = 21;
  localparam int DEPTH  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, redirect = 1'b0;
  logic [2:0] in_class = 3'd0;
  logic [31:0] in_pc = 32'h0;
  logic [DISP_W-1:0] in_disp = '0;
  logic in_ready, out_valid, pred_taken, pred_valid;
  logic [31:0] pred_target;

  int tests = 0, fails = 0;
  logic [31:0] stk[$];

  always #2 clk = ~clk;

  static_fetch_predictor #(.DISP_W(DISP_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_pc(in_pc), .in_disp(in_disp),
    .redirect(redirect), .out_valid(out_valid), .out_ready(out_ready),
    .pred_taken(pred_taken), .pred_valid(pred_valid),
    .pred_target(pred_target)
  );

  function automatic string tag(input logic [2:0] c);
    case (c)
      3'd1: return "R1/R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5/R6/R7";
      default: return "R9";
    endcase
  endfunction

  // One cycle: drive at negedge, compare before posedge, update model.
  task automatic step(input logic v, input logic [2:0] c, input logic [31:0] pc,
                      input int d, input logic rdy, input logic rd);
    logic [31:0] seq, br, et;
    logic ev, etk, eiv;
    @(negedge clk);
    in_valid = v; in_class = c; in_pc = pc; in_disp = DISP_W'(d);
    out_ready = rdy; redirect = rd;
    #1;
    seq = pc + 32'd4;
    br  = seq + (32'(d) << 2);
    et = seq; etk = 1'b0; eiv = v;
    if (c == 3'd2 || c == 3'd3) begin etk = v; et = br; end
    else if (c == 3'd1) begin if (d < 0) begin etk = v; et = br; end end
    else if (c == 3'd4) begin
      if (stk.size() == 0) eiv = 1'b0;
      else begin etk = v; et = stk[$]; end
    end
    ev = v;
    tests++;
    if (out_valid !== ev || in_ready !== rdy)
      begin fails++; $display("FAIL R10 valid/ready got %b/%b exp %b/%b", out_valid, in_ready, ev, rdy); end
    else if (pred_taken !== etk || pred_valid !== eiv || pred_target !== et)
      begin fails++; $display("FAIL %s cls=%0d taken/valid/target got %b/%b/%h exp %b/%b/%h",
        (c == 3'd4 && rd == 1'b0 && stk.size() == 0) ? "R7" : tag(c), c,
        pred_taken, pred_valid, pred_target, etk, eiv, et); end
    if (rd) stk.delete();
    else if (v && rdy) begin
      if (c == 3'd3) begin stk.push_back(seq); if (stk.size() > DEPTH) void'(stk.pop_front()); end
      else if (c == 3'd4 && stk.size() > 0) void'(stk.pop_back());
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state: return on empty stack (R7)
    step(1, 3'd4, 32'h100, 0, 1, 0);
    step(0, 3'd0, 32'h0, 0, 1, 0);               // R10 idle
    step(1, 3'd1, 32'h200, -3, 1, 0);             // R1
    step(1, 3'd1, 32'h200, 0, 1, 0);              // R2 zero
    step(1, 3'd1, 32'h200, 5, 1, 0);              // R2 positive
    step(1, 3'd2, 32'h300, -100, 1, 0);           // R3
    step(1, 3'd2, 32'h300, 77, 1, 0);             // R3
    step(1, 3'd0, 32'h400, -8, 1, 0);             // R9
    step(1, 3'd7, 32'h404, -8, 1, 0);             // R9 unused code
    // R4/R5 LIFO
    step(1, 3'd3, 32'h1000, 16, 1, 0);
    step(1, 3'd3, 32'h2000, 16, 1, 0);
    step(1, 3'd4, 32'h3000, 0, 1, 0);
    step(1, 3'd4, 32'h3004, 0, 1, 0);
    step(1, 3'd4, 32'h3008, 0, 1, 0);             // R7 empty again
    // R6 overflow: six calls, four most recent survive
    for (int i = 0; i < 6; i++) step(1, 3'd3, 32'h5000 + 32'(i*16), 1, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 3'd4, 32'h6000, 0, 1, 0);
    // R10 stall: call and return not consumed
    step(1, 3'd3, 32'h7000, 2, 1, 0);
    step(1, 3'd3, 32'h7100, 2, 0, 0);
    step(1, 3'd4, 32'h7200, 0, 0, 0);
    step(0, 3'd4, 32'h7200, 0, 1, 0);
    step(1, 3'd4, 32'h7300, 0, 1, 0);
    // R8 redirect, with a same-cycle call
    step(1, 3'd3, 32'h8000, 2, 1, 0);
    step(1, 3'd3, 32'h8100, 2, 1, 1);
    step(1, 3'd4, 32'h8200, 0, 1, 0);
    // Mixed traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) != 0, 3'($urandom % 6), $urandom & 32'hFFFF_FFFC,
           int'($urandom % 4096) - 2048, ($urandom % 6) != 0, ($urandom % 40) == 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule